// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns parallel audio sample words into a serial data stream, one bit per bit period, and produces the matching frame sync and bit clock. A single static format selector picks one of four two-channel framings: the classic inter-IC sound layout (sync one word wide, low while active, leading the data by one bit), left-aligned (sync one word wide, high, aligned with the first bit), and two short-pulse layouts (one-bit high sync, either one bit early or aligned). Separate invert controls flip the bit-clock and frame-sync polarity on top of the chosen format.

Timing comes from a bit-clock enable tick: every tick moves the generated bit clock by half a period. Data and sync change on the falling half (nominal polarity) and are stable at the rising half, where a receiver samples them. Samples arrive on a valid/ready port and are taken one per active slot, at the launch of that slot's first bit. Word length, number of slots, bit order and a per-slot mask are run-time inputs. Turning the enable on starts a run with one lead bit; turning it off finishes the frame in progress before the block goes quiet.

Top module: `audtx_serializer`

## Requirements
- R1: After reset the data line is 0, the frame sync sits at its inactive level, the bit clock sits at 0 XOR the bit-clock invert input, and active, ready and underrun outputs are 0.
- R2: Each tick flips the bit clock; data and sync change only at the edge where the bit clock moves from 1 to 0 (nominal polarity), so they are stable when it rises.
- R3: Format code 0 gives a one-word sync, low when active, asserted one bit before the first data bit of its slot 0; code 1 gives a one-word sync, high, aligned with slot 0; code 2 gives a one-bit high pulse one bit before the first bit of the frame; code 3 gives a one-bit high pulse on that first bit.
- R4: The frame-sync invert input XORs the format's sync level and the bit-clock invert input XORs the bit clock; data and sync still change on the (now inverted) falling edge.
- R5: A frame is the slot count times the word length in bits; every slot uses the configured word length, from 2 up to the maximum.
- R6: With MSB-first set the first bit of a slot is bit (word length - 1) of its sample, counting down; otherwise it is bit 0, counting up.
- R7: Slot s is unused when mask bit s is 1: the data line is 0, the output-enable is low (parameter MASK_HIZ=1, the default) and no sample is taken.
- R8: If no sample is valid when an active slot starts, that slot sends zeros and the underrun output goes high and stays high until the next run starts.
- R9: Clearing the enable stops output only after the last bit of the current frame; the active output stays 1 until then, and in early-sync formats no lead-in sync is sent for a frame that will not follow.
- R10: Raising the enable from idle sends one lead bit (data 0, sync active only in the early formats) before slot 0; exactly one sample is taken per active slot, at that slot's first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_tick_i | input | 1 | Half bit-period enable tick |
| enable_i | input | 1 | Run request |
| cfg_fmt_i | input | 2 | Framing format code (0..3) |
| cfg_fs_inv_i | input | 1 | Invert frame-sync level |
| cfg_bclk_inv_i | input | 1 | Invert bit clock |
| cfg_msb_first_i | input | 1 | Most significant bit first |
| cfg_word_len_i | input | $clog2(MAX_WL+1) | Bits per slot |
| cfg_slots_i | input | $clog2(MAX_SLOTS+1) | Slots per frame |
| cfg_slot_mask_i | input | MAX_SLOTS | 1 marks a slot unused |
| smp_data_i | input | MAX_WL | Sample word |
| smp_valid_i | input | 1 | Sample word present |
| smp_ready_o | output | 1 | Sample taken this cycle |
| bclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Data output enable |
| active_o | output | 1 | Run in progress |
| underrun_o | output | 1 | Sticky missing-sample flag |

## Verification
A wrong slot or bit position shows up within one bit period as a data bit taken from the wrong index or a sync edge in the wrong place, so every received bit is compared against a model of the format. A stale stop or continue decision shows as an extra frame or a missing lead-in sync at the frame boundary, caught by counting bits after the enable drops and by checking the active output. A wrong take decision leaves samples unconsumed or raises underrun, both visible at the end of each run.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    // Framing format selector
    typedef enum logic [1:0] {
        FMT_WIDE_EARLY_LOW  = 2'd0,
        FMT_WIDE_ALIGNED    = 2'd1,
        FMT_PULSE_EARLY     = 2'd2,
        FMT_PULSE_ALIGNED   = 2'd3
    } fmt_e;

    // Decoded sync shape
    typedef struct packed {
        logic wide;     // sync lasts a whole word
        logic early;    // sync leads data by one bit
        logic low;      // active level is low
    } sync_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2
    } st_e;

endpackage

// File: rtl/audtx_fmt_dec.sv
module audtx_fmt_dec
    import audtx_pkg::*;
(
    input  logic [1:0] fmt_i,
    input  logic       fs_inv_i,
    output sync_cfg_t  sync_o
);

    always_comb begin
        sync_o = '0;
        unique case (fmt_e'(fmt_i))
            FMT_WIDE_EARLY_LOW: begin
                sync_o.wide  = 1'b1;
                sync_o.early = 1'b1;
                sync_o.low   = 1'b1;
            end
            FMT_WIDE_ALIGNED: begin
                sync_o.wide  = 1'b1;
            end
            FMT_PULSE_EARLY: begin
                sync_o.early = 1'b1;
            end
            default: begin
                sync_o.wide  = 1'b0;
            end
        endcase
        // polarity flip applies on top of the format default
        sync_o.low = sync_o.low ^ fs_inv_i;
    end

endmodule

// File: rtl/audtx_bclk_gen.sv
module audtx_bclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic inv_i,
    output logic launch_o,
    output logic bclk_o
);

    logic phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (tick_i) phase_d = ~phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    // a tick in the high half ends the bit period: next bit goes out
    assign launch_o = tick_i & phase_q;
    assign bclk_o   = phase_q ^ inv_i;

    a_r2_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/audtx_framer.sv
module audtx_framer
    import audtx_pkg::*;
#(
    parameter int MAX_WL    = 32,
    parameter int MAX_SLOTS = 2,
    parameter bit MASK_HIZ  = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           launch_i,
    input  logic                           enable_i,
    input  sync_cfg_t                      sync_i,
    input  logic                           msb_first_i,
    input  logic [$clog2(MAX_WL+1)-1:0]    wl_i,
    input  logic [$clog2(MAX_SLOTS+1)-1:0] slots_i,
    input  logic [MAX_SLOTS-1:0]           mask_i,
    input  logic [MAX_WL-1:0]              smp_data_i,
    input  logic                           smp_valid_i,
    output logic                           smp_ready_o,
    output logic                           sd_o,
    output logic                           oe_o,
    output logic                           fs_act_o,
    output logic                           active_o,
    output logic                           underrun_o
);

    localparam int BW  = (MAX_WL > 1) ? $clog2(MAX_WL) : 1;
    localparam int SW  = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
    localparam int WLW = $clog2(MAX_WL + 1);
    localparam int SCW = $clog2(MAX_SLOTS + 1);

    typedef struct packed {
        st_e               st;
        logic [SW-1:0]     slot;
        logic [BW-1:0]     bitn;
        logic [MAX_WL-1:0] word;
        logic              sd;
        logic              oe;
        logic              fs;
        logic              stop;   // enable seen low during this run
        logic              go_on;  // another frame follows the current one
        logic              unr;
    } frm_t;

    frm_t r_d, r_q;

    logic           take;
    logic           enter;
    logic [SW-1:0]  ns;
    logic [BW-1:0]  nb;
    logic [WLW-1:0] wl_m1;
    logic [SCW-1:0] sl_m1;
    logic           last_bit, last_slot;
    logic           n_last, n_masked, cont;
    logic [BW-1:0]  idx;

    always_comb begin
        r_d   = r_q;
        take  = 1'b0;
        enter = 1'b0;
        ns    = '0;
        nb    = '0;
        wl_m1 = wl_i - WLW'(1);
        sl_m1 = slots_i - SCW'(1);
        last_bit  = (WLW'(r_q.bitn) == wl_m1);
        last_slot = (SCW'(r_q.slot) == sl_m1);

        if (r_q.st != ST_IDLE && !enable_i) r_d.stop = 1'b1;

        if (launch_i) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (enable_i) begin
                        r_d.st   = ST_LEAD;
                        r_d.unr  = 1'b0;
                        r_d.stop = 1'b0;
                        r_d.sd   = 1'b0;
                        r_d.oe   = 1'b1;
                        r_d.fs   = sync_i.early;
                        r_d.slot = '0;
                        r_d.bitn = '0;
                    end
                end
                ST_LEAD: begin
                    enter  = 1'b1;
                    r_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (!last_bit) begin
                        enter = 1'b1;
                        ns    = r_q.slot;
                        nb    = r_q.bitn + 1'b1;
                    end else if (!last_slot) begin
                        enter = 1'b1;
                        ns    = r_q.slot + 1'b1;
                    end else if (r_q.go_on) begin
                        enter = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                        r_d.sd = 1'b0;
                        r_d.oe = 1'b1;
                        r_d.fs = 1'b0;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end

        n_masked = mask_i[ns];
        n_last   = (SCW'(ns) == sl_m1) && (WLW'(nb) == wl_m1);
        cont     = !r_d.stop;
        idx      = msb_first_i ? BW'(wl_m1 - WLW'(nb)) : nb;

        if (enter) begin
            r_d.slot = ns;
            r_d.bitn = nb;
            if (nb == '0 && !n_masked) begin
                take = 1'b1;
                if (smp_valid_i) begin
                    r_d.word = smp_data_i;
                end else begin
                    r_d.word = '0;
                    r_d.unr  = 1'b1;
                end
            end
            r_d.sd = n_masked ? 1'b0 : r_d.word[idx];
            r_d.oe = !(n_masked && MASK_HIZ);
            if (n_last) r_d.go_on = cont;
            if (sync_i.early) begin
                if (sync_i.wide)
                    r_d.fs = (ns == '0 && WLW'(nb) != wl_m1) || (n_last && cont);
                else
                    r_d.fs = n_last && cont;
            end else begin
                if (sync_i.wide)
                    r_d.fs = (ns == '0);
                else
                    r_d.fs = (ns == '0) && (nb == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign smp_ready_o = take;
    assign sd_o        = r_q.sd;
    assign oe_o        = r_q.oe;
    assign fs_act_o    = r_q.fs;
    assign active_o    = (r_q.st != ST_IDLE);
    assign underrun_o  = r_q.unr;

    a_r10_take_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready_o |-> launch_i);

    a_r8_underrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_o && active_o) |=> underrun_o);

    a_r9_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> $past(last_bit && last_slot && r_q.st == ST_RUN));

    a_r5_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (WLW'(r_q.bitn) < wl_i));

    a_r3_pulse_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i.wide && r_q.fs && r_q.st == ST_RUN && launch_i) |=> !r_q.fs);

endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer
    import audtx_pkg::*;
#(
    parameter int MAX_WL    = 32,
    parameter int MAX_SLOTS = 2,
    parameter bit MASK_HIZ  = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bclk_tick_i,
    input  logic                           enable_i,
    input  logic [1:0]                     cfg_fmt_i,
    input  logic                           cfg_fs_inv_i,
    input  logic                           cfg_bclk_inv_i,
    input  logic                           cfg_msb_first_i,
    input  logic [$clog2(MAX_WL+1)-1:0]    cfg_word_len_i,
    input  logic [$clog2(MAX_SLOTS+1)-1:0] cfg_slots_i,
    input  logic [MAX_SLOTS-1:0]           cfg_slot_mask_i,
    input  logic [MAX_WL-1:0]              smp_data_i,
    input  logic                           smp_valid_i,
    output logic                           smp_ready_o,
    output logic                           bclk_o,
    output logic                           fs_o,
    output logic                           sd_o,
    output logic                           sd_oe_o,
    output logic                           active_o,
    output logic                           underrun_o
);

    sync_cfg_t sync_cfg;
    logic      launch;
    logic      fs_act;

    audtx_fmt_dec u_dec (
        .fmt_i    (cfg_fmt_i),
        .fs_inv_i (cfg_fs_inv_i),
        .sync_o   (sync_cfg)
    );

    audtx_bclk_gen u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (bclk_tick_i),
        .inv_i    (cfg_bclk_inv_i),
        .launch_o (launch),
        .bclk_o   (bclk_o)
    );

    audtx_framer #(
        .MAX_WL    (MAX_WL),
        .MAX_SLOTS (MAX_SLOTS),
        .MASK_HIZ  (MASK_HIZ)
    ) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .enable_i    (enable_i),
        .sync_i      (sync_cfg),
        .msb_first_i (cfg_msb_first_i),
        .wl_i        (cfg_word_len_i),
        .slots_i     (cfg_slots_i),
        .mask_i      (cfg_slot_mask_i),
        .smp_data_i  (smp_data_i),
        .smp_valid_i (smp_valid_i),
        .smp_ready_o (smp_ready_o),
        .sd_o        (sd_o),
        .oe_o        (sd_oe_o),
        .fs_act_o    (fs_act),
        .active_o    (active_o),
        .underrun_o  (underrun_o)
    );

    assign fs_o = fs_act ^ sync_cfg.low;

    a_r2_sd_on_drive_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_o != $past(sd_o)) |-> ($past(bclk_o) == ~cfg_bclk_inv_i && bclk_o == cfg_bclk_inv_i));

endmodule

// File: tb/tb_audtx_serializer.sv
module tb_audtx_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_WL     = 32;
    localparam int MAX_SLOTS  = 2;
    localparam bit MASK_HIZ   = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_fs_inv = 1'b0;
    logic        cfg_bclk_inv = 1'b0;
    logic        cfg_msb = 1'b1;
    logic [5:0]  cfg_wl = 6'd16;
    logic [1:0]  cfg_slots = 2'd2;
    logic [1:0]  cfg_mask = 2'b00;
    logic [31:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, bclk, fs, sd, sd_oe, active, underrun;

    always #(CLK_PERIOD/2) clk = ~clk;

    audtx_serializer #(.MAX_WL(MAX_WL), .MAX_SLOTS(MAX_SLOTS), .MASK_HIZ(MASK_HIZ)) dut (
        .clk(clk), .rst_n(rst_n), .bclk_tick_i(tick), .enable_i(enable),
        .cfg_fmt_i(cfg_fmt), .cfg_fs_inv_i(cfg_fs_inv), .cfg_bclk_inv_i(cfg_bclk_inv),
        .cfg_msb_first_i(cfg_msb), .cfg_word_len_i(cfg_wl), .cfg_slots_i(cfg_slots),
        .cfg_slot_mask_i(cfg_mask), .smp_data_i(smp_data), .smp_valid_i(smp_valid),
        .smp_ready_o(smp_ready), .bclk_o(bclk), .fs_o(fs), .sd_o(sd), .sd_oe_o(sd_oe),
        .active_o(active), .underrun_o(underrun)
    );

    typedef struct { logic sd; logic fs; logic oe; } exp_t;
    exp_t        exp_q[$];
    logic [31:0] smp_q[$];
    int          n_chk = 0;
    int          n_err = 0;
    int          bits_seen = 0;
    string       sd_tag = "R5";
    string       fs_tag = "R3";
    bit          hs = 1'b0;
    logic        prev_bclk = 1'b0;
    logic        sd_half = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // sample feeder and tick source: one tick every other cycle
    initial begin
        forever begin
            @(negedge clk);
            if (hs) void'(smp_q.pop_front());
            smp_valid = (smp_q.size() > 0);
            smp_data  = smp_valid ? smp_q[0] : '0;
            tick      = ~tick;
            #1;
            hs = rst_n && smp_ready && smp_valid;
        end
    end

    // monitor: compare each bit at the receiver sampling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (active && bclk == ~cfg_bclk_inv && prev_bclk != bclk) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 bit after frame end", {31'd0, sd}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(sd == e.sd, sd_tag, {31'd0, sd}, {31'd0, e.sd});
                    chk(fs == e.fs, fs_tag, {31'd0, fs}, {31'd0, e.fs});
                    chk(sd_oe == e.oe, "R7 output enable", {31'd0, sd_oe}, {31'd0, e.oe});
                    chk(sd == sd_half, "R2 data stable in high half", {31'd0, sd}, {31'd0, sd_half});
                    bits_seen++;
                end
            end
            prev_bclk = bclk;
            sd_half   = sd;
        end
    end

    task automatic run_case(input logic [1:0] fmt, input bit fsi, input bit bi, input bit msb,
                            input int wl, input int slots, input logic [1:0] mask,
                            input int nf, input bit data, input string dtag, input string ftag,
                            input bit exp_unr);
        bit   wide, early, low, last, cont, act;
        logic [31:0] w;
        int   base, n_bits;
        exp_t e;
        wide  = (fmt <= 2'd1);
        early = (fmt == 2'd0) || (fmt == 2'd2);
        low   = (fmt == 2'd0) ^ fsi;
        @(negedge clk);
        cfg_fmt = fmt; cfg_fs_inv = fsi; cfg_bclk_inv = bi; cfg_msb = msb;
        cfg_wl = 6'(wl); cfg_slots = 2'(slots); cfg_mask = mask;
        sd_tag = dtag; fs_tag = ftag;
        n_bits = slots * wl;
        // lead bit (R10)
        e.sd = 1'b0; e.oe = 1'b1; e.fs = early ^ low;
        exp_q.push_back(e);
        for (int f = 0; f < nf; f++) begin
            for (int s = 0; s < slots; s++) begin
                w = '0;
                if (!mask[s] && data) begin
                    w = $urandom();
                    smp_q.push_back(w);
                end
                for (int b = 0; b < wl; b++) begin
                    last = (s == slots - 1) && (b == wl - 1);
                    cont = (f < nf - 1);
                    if (early) act = wide ? ((s == 0 && b != wl - 1) || (last && cont)) : (last && cont);
                    else       act = wide ? (s == 0) : (s == 0 && b == 0);
                    e.sd = mask[s] ? 1'b0 : w[msb ? (wl - 1 - b) : b];
                    e.oe = mask[s] ? !MASK_HIZ : 1'b1;
                    e.fs = act ^ low;
                    exp_q.push_back(e);
                end
            end
        end
        base = bits_seen;
        enable = 1'b1;
        while (bits_seen < base + 2 + (nf - 1) * n_bits) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(active == 1'b1, "R9 active held after enable drop", {31'd0, active}, 32'd1);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(active == 1'b0, "R9 stopped at frame end", {31'd0, active}, 32'd0);
        chk(bits_seen == base + 1 + nf * n_bits, "R5 bits per run", bits_seen - base, 1 + nf * n_bits);
        chk(smp_q.size() == 0, "R10 one sample per active slot", smp_q.size(), 32'd0);
        chk(underrun == exp_unr, "R8 underrun flag", {31'd0, underrun}, {31'd0, exp_unr});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values (format 0 idles with sync high)
        chk(sd == 1'b0, "R1 data", {31'd0, sd}, 32'd0);
        chk(fs == 1'b1, "R1 sync idle level", {31'd0, fs}, 32'd1);
        chk(bclk == 1'b0, "R1 bit clock", {31'd0, bclk}, 32'd0);
        chk(active == 1'b0, "R1 active", {31'd0, active}, 32'd0);
        chk(smp_ready == 1'b0, "R1 ready", {31'd0, smp_ready}, 32'd0);
        chk(underrun == 1'b0, "R1 underrun", {31'd0, underrun}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 wide early low-active, MSB first
        run_case(2'd0, 1'b0, 1'b0, 1'b1, 16, 2, 2'b00, 3, 1'b1, "R5", "R3", 1'b0);
        // R6 LSB first, wide aligned
        run_case(2'd1, 1'b0, 1'b0, 1'b0, 8, 2, 2'b00, 2, 1'b1, "R6", "R3", 1'b0);
        // R3 one-bit pulse, early
        run_case(2'd2, 1'b0, 1'b0, 1'b1, 12, 2, 2'b00, 2, 1'b1, "R5", "R3", 1'b0);
        // R4 both inversions on the aligned pulse format
        run_case(2'd3, 1'b1, 1'b1, 1'b1, 8, 2, 2'b00, 2, 1'b1, "R4", "R4", 1'b0);
        // R7 slot 1 unused
        run_case(2'd1, 1'b0, 1'b0, 1'b1, 8, 2, 2'b10, 2, 1'b1, "R7", "R3", 1'b0);
        // R5 single slot with upper mask bit set
        run_case(2'd3, 1'b0, 1'b0, 1'b0, 24, 1, 2'b10, 2, 1'b1, "R5", "R3", 1'b0);
        // R8 no samples at all
        run_case(2'd0, 1'b0, 1'b0, 1'b1, 8, 2, 2'b00, 1, 1'b0, "R8", "R3", 1'b1);
        // R8 flag cleared by a clean run
        run_case(2'd0, 1'b0, 1'b0, 1'b1, 8, 2, 2'b00, 2, 1'b1, "R8", "R3", 1'b0);
        // R5 maximum word length
        run_case(2'd2, 1'b0, 1'b0, 1'b1, 32, 2, 2'b00, 1, 1'b1, "R5", "R3", 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule